// File: doc/BRIEF.md
# Burst SPI Master Controller

This block is an SPI master that software drives through a small 32-bit register bus. Software writes bytes into a transmit queue and programs two byte counts: the length of the burst, and how many of those bytes come from the queue. It then sets a self-clearing start bit in the transfer control word. The engine shifts one byte after another on the serial lines. Every byte it receives goes into a receive queue, which software drains one byte per read.

The serial clock is paced by a one-cycle enable from an external divider. Each enable pulse is one half period of the serial clock, so a byte takes sixteen pulses. Clock polarity and phase come from two control bits. During a burst the block drives chip-select on its own, unless software has claimed the line and sets its level directly. A sticky, write-one-to-clear completion flag marks the end of every burst.

Top module: `burst_spi_master`

## Requirements
- R1: After reset the version word at offset 0x000 reads 0x00010000 (major in bits 31:16, minor in bits 15:0). The transfer control word at 0x008 reads 0x00000080, the status word at 0x014 reads 0x00000002, the queue level word at 0x01C reads 0, chip-select is high and the serial clock is low.
- R2: A start request (write with bit 31 set to 0x008) is ignored unless both the enable bit (bit 0) and the master bit (bit 1) of the word at 0x004 are 1. An ignored request leaves bit 31 reading 0, chip-select high and the completion flag clear.
- R3: Bit 31 of 0x008 reads 1 while a burst runs and clears itself when the burst ends. Bit 12 of 0x014 is set in the same cycle that bit 31 clears, and writing 1 to bit 12 clears it.
- R4: Bits are sent MSB first. The serial clock rests at the level of bit 1 of 0x008 (polarity). With bit 0 (phase) at 0, data is sampled on the leading clock edge; with phase at 1, on the trailing edge. Each byte takes sixteen divider pulses.
- R5: A burst moves exactly the count held in bits 6:0 of 0x030. The first N bytes, N being bits 6:0 of 0x034, are popped from the transmit queue. Every later byte, and any byte met while the queue is empty, is sent as 0x00.
- R6: Every received byte is pushed into the receive queue. A read of 0x300 returns the oldest byte in bits 7:0 and pops it.
- R7: While a burst runs and bit 6 of 0x008 is 0, chip-select is low, and it is high otherwise. When bit 6 is 1, chip-select follows bit 7 of 0x008 (0 drives it low) and ignores burst activity.
- R8: Writing 1 to bit 15 of 0x018 empties the receive queue, and writing 1 to bit 31 empties the transmit queue. Offset 0x018 reads 0.
- R9: Each queue holds 64 bytes. A write to 0x200 pushes bits 7:0, and a push into a full queue is dropped. Offset 0x01C reports the receive level in bits 7:0 and the transmit level in bits 23:16.
- R10: Bit 1 of 0x014 reads 1 exactly when the receive queue is empty.
- R11: The burst count (0x030) and the queue-byte count (0x034) read back the value written to bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; pops the receive queue at 0x300 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk_en | input | 1 | Half-period pulse from the external divider |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip-select, active low |

## Verification
A register write takes effect at the clock edge that ends its cycle. The bench therefore reads back from the following cycle and samples at the falling edge, after the read mux has settled on the same-cycle address. The length of a burst depends on the divider, so the bench does not count a fixed number of cycles: it polls bit 31 and checks the completion flag, the queue levels and chip-select in the first read after the bit drops, which is when R3 says they are due. Serial bits are taken by a bench monitor on the sampling edge picked by polarity and phase, and MISO is looped back to MOSI, so each received byte must equal the byte sent.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_VERSION  = 12'h000;
  localparam logic [REG_AW-1:0] OFS_GLOBAL   = 12'h004;
  localparam logic [REG_AW-1:0] OFS_XFER     = 12'h008;
  localparam logic [REG_AW-1:0] OFS_ISTAT    = 12'h014;
  localparam logic [REG_AW-1:0] OFS_FIFOCTL  = 12'h018;
  localparam logic [REG_AW-1:0] OFS_FIFOSTAT = 12'h01C;
  localparam logic [REG_AW-1:0] OFS_BURST    = 12'h030;
  localparam logic [REG_AW-1:0] OFS_TXCNT    = 12'h034;
  localparam logic [REG_AW-1:0] OFS_TXDATA   = 12'h200;
  localparam logic [REG_AW-1:0] OFS_RXDATA   = 12'h300;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_SHIFT, ENG_DONE} eng_state_t;

  // Byte placed on the wire: queue head while quota remains and data exists, else zero fill.
  function automatic logic [7:0] pick_tx_byte(input logic quota_left, input logic q_empty,
                                              input logic [7:0] head);
    return (quota_left && !q_empty) ? head : 8'h00;
  endfunction

  // Queue level word: receive level low byte, transmit level in bits 23:16.
  function automatic logic [31:0] pack_levels(input logic [7:0] rx_lvl, input logic [7:0] tx_lvl);
    return {8'h00, tx_lvl, 8'h00, rx_lvl};
  endfunction
endpackage

// File: rtl/bsm_fifo.sv
module bsm_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [WIDTH-1:0]             din_i,
  input  logic                         pop_i,
  output logic [WIDTH-1:0]             dout_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_next(wp_q);
      if (do_pop)  rp_q <= ptr_next(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !clr_i) |=> $stable(count_o)) else $error("full push changed level"); // R9
  AST_FIFO_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> empty_o) else $error("clear left data"); // R8
endmodule

// File: rtl/bsm_shifter.sv
module bsm_shifter #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic            start_i,
  input  logic [BITS-1:0] byte_i,
  input  logic            miso_i,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [BITS-1:0] byte_o
);
  localparam int unsigned EDGES = 2 * BITS;
  localparam int unsigned EW    = $clog2(EDGES);

  logic [BITS-1:0] txs_q, rxs_q;
  logic [EW-1:0]   edge_q;
  logic            ph_q, busy_q, done_q, mosi_q;
  logic            lead, out_edge, samp_edge, last_edge;

  assign lead      = !edge_q[0];
  assign last_edge = (edge_q == EW'(EDGES-1));
  assign out_edge  = cpha_i ? lead : (!lead && !last_edge);
  assign samp_edge = cpha_i ? !lead : lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs_q  <= '0;
      rxs_q  <= '0;
      edge_q <= '0;
      ph_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      done_q <= busy_q && tick_i && last_edge;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        ph_q   <= 1'b0;
        if (!cpha_i) begin
          mosi_q <= byte_i[BITS-1];
          txs_q  <= {byte_i[BITS-2:0], 1'b0};
        end else begin
          txs_q  <= byte_i;
        end
      end else if (busy_q && tick_i) begin
        ph_q   <= !ph_q;
        edge_q <= edge_q + 1'b1;
        if (out_edge) begin
          mosi_q <= txs_q[BITS-1];
          txs_q  <= {txs_q[BITS-2:0], 1'b0};
        end
        if (samp_edge) rxs_q <= {rxs_q[BITS-2:0], miso_i};
        if (last_edge) busy_q <= 1'b0;
      end
    end
  end

  assign sclk_o = cpol_i ^ ph_q;
  assign mosi_o = mosi_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign byte_o = rxs_q;

  AST_SCLK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sclk_o == cpol_i)) else $error("clock not at rest after byte"); // R4
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o) else $error("byte started while shifting"); // R5
endmodule

// File: rtl/burst_spi_master.sv
module burst_spi_master import bsm_pkg::*; #(
  parameter int unsigned DEPTH     = 64,
  parameter logic [15:0] VER_MAJOR = 16'd1,
  parameter logic [15:0] VER_MINOR = 16'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sclk_en,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic en_q, master_q, cpha_q, cpol_q, cs_own_q, cs_lvl_q, xchg_q, tc_q;
  logic [CW-1:0] burst_len_q, tx_len_q, burst_left_q, tx_left_q;
  eng_state_t    state_q;

  logic wr_global, wr_xfer, wr_istat, wr_fifoctl, wr_burst, wr_txcnt, wr_txdata;
  logic xchg_start, tx_quota, burst_end;
  logic tx_push, tx_pop, tx_clr, tx_empty, tx_full;
  logic rx_push, rx_pop, rx_clr, rx_empty, rx_full;
  logic [7:0] tx_head, rx_head, shift_byte, shift_rx;
  logic [CW-1:0] tx_lvl, rx_lvl;
  logic shift_start, shift_busy, shift_done;
  logic unused_bits;

  assign unused_bits = ^{bus_wdata, tx_full, rx_full};

  // Register decode
  assign wr_global  = bus_we && (bus_addr == OFS_GLOBAL);
  assign wr_xfer    = bus_we && (bus_addr == OFS_XFER);
  assign wr_istat   = bus_we && (bus_addr == OFS_ISTAT);
  assign wr_fifoctl = bus_we && (bus_addr == OFS_FIFOCTL);
  assign wr_burst   = bus_we && (bus_addr == OFS_BURST);
  assign wr_txcnt   = bus_we && (bus_addr == OFS_TXCNT);
  assign wr_txdata  = bus_we && (bus_addr == OFS_TXDATA);

  // Named internal events
  assign xchg_start  = wr_xfer && bus_wdata[31] && en_q && master_q && !xchg_q
                       && (state_q == ENG_IDLE);
  assign tx_quota    = (tx_left_q != '0);
  assign shift_start = (state_q == ENG_LOAD);
  assign shift_byte  = pick_tx_byte(tx_quota, tx_empty, tx_head);
  assign tx_pop      = shift_start && tx_quota && !tx_empty;
  assign tx_push     = wr_txdata;
  assign tx_clr      = wr_fifoctl && bus_wdata[31];
  assign rx_clr      = wr_fifoctl && bus_wdata[15];
  assign rx_push     = shift_done;
  assign rx_pop      = bus_re && (bus_addr == OFS_RXDATA);
  assign burst_end   = (state_q == ENG_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      master_q     <= 1'b0;
      cpha_q       <= 1'b0;
      cpol_q       <= 1'b0;
      cs_own_q     <= 1'b0;
      cs_lvl_q     <= 1'b1;
      xchg_q       <= 1'b0;
      tc_q         <= 1'b0;
      burst_len_q  <= '0;
      tx_len_q     <= '0;
      burst_left_q <= '0;
      tx_left_q    <= '0;
      state_q      <= ENG_IDLE;
    end else begin
      if (wr_global) begin
        en_q     <= bus_wdata[0];
        master_q <= bus_wdata[1];
      end
      if (wr_xfer) begin
        cpha_q   <= bus_wdata[0];
        cpol_q   <= bus_wdata[1];
        cs_own_q <= bus_wdata[6];
        cs_lvl_q <= bus_wdata[7];
      end
      if (wr_burst) burst_len_q <= bus_wdata[CW-1:0];
      if (wr_txcnt) tx_len_q    <= bus_wdata[CW-1:0];

      if (burst_end)                    tc_q <= 1'b1;
      else if (wr_istat && bus_wdata[12]) tc_q <= 1'b0;

      case (state_q)
        ENG_IDLE: if (xchg_start) begin
          xchg_q       <= 1'b1;
          burst_left_q <= burst_len_q;
          tx_left_q    <= tx_len_q;
          state_q      <= (burst_len_q == '0) ? ENG_DONE : ENG_LOAD;
        end
        ENG_LOAD: begin
          if (tx_quota) tx_left_q <= tx_left_q - 1'b1;
          state_q <= ENG_SHIFT;
        end
        ENG_SHIFT: if (shift_done) begin
          burst_left_q <= burst_left_q - 1'b1;
          state_q      <= (burst_left_q == CW'(1)) ? ENG_DONE : ENG_LOAD;
        end
        default: begin
          xchg_q  <= 1'b0;
          state_q <= ENG_IDLE;
        end
      endcase
    end
  end

  bsm_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr_i(tx_clr), .push_i(tx_push), .din_i(bus_wdata[7:0]),
    .pop_i(tx_pop), .dout_o(tx_head), .empty_o(tx_empty), .full_o(tx_full), .count_o(tx_lvl));

  bsm_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .push_i(rx_push), .din_i(shift_rx),
    .pop_i(rx_pop), .dout_o(rx_head), .empty_o(rx_empty), .full_o(rx_full), .count_o(rx_lvl));

  bsm_shifter #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(sclk_en), .cpol_i(cpol_q), .cpha_i(cpha_q),
    .start_i(shift_start), .byte_i(shift_byte), .miso_i(spi_miso), .sclk_o(spi_sclk),
    .mosi_o(spi_mosi), .busy_o(shift_busy), .done_o(shift_done), .byte_o(shift_rx));

  assign spi_cs_n = cs_own_q ? cs_lvl_q : !xchg_q;

  always_comb begin
    case (bus_addr)
      OFS_VERSION:  bus_rdata = {VER_MAJOR, VER_MINOR};
      OFS_GLOBAL:   bus_rdata = {30'b0, master_q, en_q};
      OFS_XFER:     bus_rdata = {xchg_q, 23'b0, cs_lvl_q, cs_own_q, 4'b0, cpol_q, cpha_q};
      OFS_ISTAT:    bus_rdata = {19'b0, tc_q, 10'b0, rx_empty, 1'b0};
      OFS_FIFOSTAT: bus_rdata = pack_levels(8'(rx_lvl), 8'(tx_lvl));
      OFS_BURST:    bus_rdata = 32'(burst_len_q);
      OFS_TXCNT:    bus_rdata = 32'(tx_len_q);
      OFS_RXDATA:   bus_rdata = {24'b0, rx_head};
      default:      bus_rdata = 32'b0;
    endcase
  end

  AST_XCHG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xchg_q) |-> (en_q && master_q)) else $error("burst began while disabled"); // R2
  AST_TC_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xchg_q) |-> tc_q) else $error("burst ended without completion flag"); // R3
  AST_CS_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_busy && !cs_own_q) |-> !spi_cs_n) else $error("chip-select high while shifting"); // R7
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |-> ((state_q == ENG_SHIFT) && (burst_left_q != '0))) else $error("byte beyond burst"); // R5
endmodule

// File: tb/burst_spi_master_bench.sv
`timescale 1ns/1ps
module burst_spi_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk_en = 1'b0;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int n_chk = 0;
  int n_fail = 0;
  logic cur_cpol = 1'b0;
  logic cur_cpha = 1'b0;

  always #5 clk = ~clk;
  assign spi_miso = spi_mosi;

  burst_spi_master u_burst_spi_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_en(sclk_en), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  // Divider model: one enable pulse every second cycle
  initial begin
    forever begin
      @(negedge clk); sclk_en = 1'b1;
      @(negedge clk); sclk_en = 1'b0;
    end
  end

  // Wire monitor: bits taken on the sampling edge chosen by polarity and phase
  int mon_total = 0;
  int bitc = 0;
  logic [7:0] capb = '0;
  logic [7:0] mon [0:255];
  always @(spi_sclk) begin
    if (rst_n && !spi_cs_n && (spi_sclk === (cur_cpol ^ !cur_cpha))) begin
      capb = {capb[6:0], spi_mosi};
      bitc++;
      if (bitc == 8) begin
        mon[mon_total % 256] = capb;
        mon_total++;
        bitc = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] d;
    for (int k = 0; k < 4000; k++) begin
      rd(12'h008, d);
      if (!d[31]) break;
    end
  endtask

  // {cpol, cpha, burst[6:0], queue bytes[6:0], pushes[6:0], seed[7:0]}
  localparam logic [30:0] VECS [6] = '{
    {1'b0, 1'b0, 7'd4,  7'd4,  7'd4,  8'hA5},
    {1'b0, 1'b1, 7'd3,  7'd3,  7'd3,  8'h3C},
    {1'b1, 1'b0, 7'd5,  7'd2,  7'd5,  8'h81},
    {1'b1, 1'b1, 7'd6,  7'd6,  7'd3,  8'hF0},
    {1'b0, 1'b0, 7'd64, 7'd64, 7'd64, 8'h00},
    {1'b0, 1'b1, 7'd1,  7'd0,  7'd0,  8'h5A}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, d); chk("R1 version", d, 32'h0001_0000);
    rd(12'h008, d); chk("R1 xfer ctrl", d, 32'h0000_0080);
    rd(12'h014, d); chk("R1 R10 status", d, 32'h0000_0002);
    rd(12'h01C, d); chk("R1 levels", d, 32'h0);
    chk("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
    chk("R1 sclk", {31'b0, spi_sclk}, 32'h0);

    // R2 start ignored while disabled
    wr(12'h030, 32'd2);
    wr(12'h008, 32'h8000_0080);
    rd(12'h008, d); chk("R2 start ignored", d, 32'h0000_0080);
    repeat (40) @(negedge clk);
    chk("R2 cs_n stays high", {31'b0, spi_cs_n}, 32'h1);
    rd(12'h014, d); chk("R2 no completion", d, 32'h0000_0002);
    wr(12'h004, 32'h3);

    // Table of bursts
    for (int v = 0; v < 6; v++) begin
      logic [30:0] e;
      int nb, nt, np, used;
      logic [7:0] sd, ex;
      e = VECS[v];
      nb = int'(e[28:22]); nt = int'(e[21:15]); np = int'(e[14:8]); sd = e[7:0];
      used = (nt < np) ? nt : np;
      cur_cpol = e[30]; cur_cpha = e[29];
      wr(12'h008, {24'b0, 8'h80} | {30'b0, e[30], e[29]});
      wr(12'h018, 32'h8000_8000);
      for (int i = 0; i < np; i++) wr(12'h200, {24'b0, sd + 8'(i)});
      wr(12'h030, nb);
      wr(12'h034, nt);
      rd(12'h034, d); chk("R11 count readback", d, nt);
      base = mon_total;
      wr(12'h008, 32'h8000_0080 | {30'b0, e[30], e[29]});
      rd(12'h008, d); chk("R3 busy bit", {31'b0, d[31]}, 32'h1);
      chk("R7 cs low in burst", {31'b0, spi_cs_n}, 32'h0);
      wait_done();
      chk("R7 cs released", {31'b0, spi_cs_n}, 32'h1);
      chk("R4 clock rest level", {31'b0, spi_sclk}, {31'b0, e[30]});
      rd(12'h014, d); chk("R3 R10 flag at end", d, 32'h0000_1000);
      rd(12'h01C, d); chk("R5 R9 levels", d, {8'h0, 8'(np - used), 8'h0, 8'(nb)});
      chk("R5 bytes on wire", mon_total - base, nb);
      for (int i = 0; i < nb; i++) begin
        ex = (i < used) ? sd + 8'(i) : 8'h00;
        chk("R4 R5 mosi byte", {24'b0, mon[(base + i) % 256]}, {24'b0, ex});
        rd(12'h300, d); chk("R6 rx byte", d, {24'b0, ex});
      end
      wr(12'h014, 32'h0000_1000);
      rd(12'h014, d); chk("R3 R10 flag cleared", d, 32'h0000_0002);
    end

    // R7 software-owned chip-select
    cur_cpol = 1'b0; cur_cpha = 1'b0;
    wr(12'h008, 32'h0000_0040);
    chk("R7 sw level low", {31'b0, spi_cs_n}, 32'h0);
    wr(12'h008, 32'h0000_00C0);
    chk("R7 sw level high", {31'b0, spi_cs_n}, 32'h1);
    wr(12'h030, 32'd1);
    wr(12'h034, 32'd0);
    rd(12'h030, d); chk("R11 burst readback", d, 32'd1);
    wr(12'h008, 32'h8000_00C0);
    rd(12'h008, d); chk("R7 busy with sw cs", d, 32'h8000_00C0);
    chk("R7 sw cs ignores burst", {31'b0, spi_cs_n}, 32'h1);
    wait_done();

    // R8 receive queue reset
    rd(12'h01C, d); chk("R6 one byte queued", d, 32'h0000_0001);
    wr(12'h018, 32'h0000_8000);
    rd(12'h01C, d); chk("R8 rx emptied", d, 32'h0);
    rd(12'h014, d); chk("R8 R10 empty flag", d, 32'h0000_1002);
    rd(12'h018, d); chk("R8 ctrl reads zero", d, 32'h0);

    // R9 overflow then R8 transmit reset
    for (int i = 0; i < 66; i++) wr(12'h200, i);
    rd(12'h01C, d); chk("R9 tx capped", d, 32'h0040_0000);
    wr(12'h018, 32'h8000_0000);
    rd(12'h01C, d); chk("R8 tx emptied", d, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule